// File: doc/BRIEF.md
# Dual-Domain Soft Reset Handshake

This block turns a software write into a reset that reaches two clock domains at different times. The host domain runs on the register bus clock. The engine domain runs on the protocol clock. A write whose reset bit is set starts the sequence. In the next host cycle the block raises a readable in-progress flag and gives a one-cycle reset pulse to the host-side logic.

A request level then crosses into the engine domain through a synchronizer. The engine-side reset is held for a fixed number of engine clocks, and then an acknowledge level crosses back to the host. The request drops only after that acknowledge has been seen. The in-progress flag clears by itself once the acknowledge has gone low again, so the flag covers the whole round trip through both domains.

The write port carries one data bit. It is bit 25 of the module configuration word on the register bus, and the bus fabric routes it here.

Top module: `srst_handshake`

## Requirements
- R1: While `host_rst` and `eng_rst` are applied, and right after they are released, `busy`, `host_srst` and `eng_srst` are all 0.
- R2: A host cycle with `wr_en`=1 and `wr_bit`=1 (configuration bit 25 set) while `busy` is 0 makes `busy` 1 after the next rising edge of `host_clk`.
- R3: `host_srst` is 1 for exactly one host cycle. That is the first cycle in which `busy` is 1 for a new reset.
- R4: A write has no effect if `wr_bit`=0, or if it arrives while `busy` is 1. No reset starts, and no extra engine reset pulse is produced.
- R5: Each accepted write produces exactly one `eng_srst` pulse, exactly ENG_HOLD engine cycles wide (default 2). The pulse starts after `busy` rises, within SYNC_STAGES+2 engine periods plus one host period.
- R6: `busy` stays 1 until after `eng_srst` has fallen. It then falls within (2*SYNC_STAGES+4) host periods plus (SYNC_STAGES+2) engine periods of that fall.
- R7: If `wr_en` and `wr_bit` are held at 1 without a break, `busy` is 0 for exactly one host cycle between consecutive resets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| host_clk | input | 1 | Register bus (host domain) clock |
| host_rst | input | 1 | Synchronous active-high reset, host domain |
| eng_clk | input | 1 | Protocol engine clock |
| eng_rst | input | 1 | Synchronous active-high reset, engine domain |
| wr_en | input | 1 | Write strobe for the configuration word |
| wr_bit | input | 1 | Soft-reset bit of the written word (bit 25) |
| busy | output | 1 | Reset in progress; clears by itself when both domains are done |
| host_srst | output | 1 | One-cycle reset pulse for host-domain state |
| eng_srst | output | 1 | Reset for engine-domain state, ENG_HOLD engine cycles wide |

## Verification
A new trigger write and the self-clear of `busy` can land on the same host edge. The write is ignored there, because the controller is still finishing the old reset. It is accepted one cycle later. The bench provokes this collision by holding the write strobe and the reset bit high across several back-to-back resets. It judges the result by counting the low cycles of `busy` between rises, which must be exactly one each time. It repeats this over a sweep of engine clock periods, both faster and slower than the host clock.

// File: rtl/srst_pkg.sv
package srst_pkg;
  typedef enum logic [1:0] {
    H_IDLE = 2'd0,
    H_REQ  = 2'd1,
    H_DROP = 2'd2
  } host_st_t;

  typedef enum logic [1:0] {
    E_IDLE = 2'd0,
    E_RST  = 2'd1,
    E_ACK  = 2'd2
  } eng_st_t;
endpackage

// File: rtl/srst_sync.sv
module srst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  localparam int N = (STAGES < 1) ? 1 : STAGES;

  logic [N-1:0] sr;

  generate
    if (N == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) sr <= '0;
        else     sr <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sr <= '0;
        else     sr <= {sr[N-2:0], d};
      end
    end
  endgenerate

  assign q = sr[N-1];
endmodule

// File: rtl/srst_host_ctl.sv
module srst_host_ctl
  import srst_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic wr_en,
  input  logic wr_bit,
  input  logic ack_sync,
  output logic busy,
  output logic host_srst,
  output logic req
);
  host_st_t st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= H_IDLE;
      busy      <= 1'b0;
      host_srst <= 1'b0;
      req       <= 1'b0;
    end else begin
      host_srst <= 1'b0;
      case (st)
        H_IDLE: begin
          if (wr_en && wr_bit) begin
            st        <= H_REQ;
            busy      <= 1'b1;
            host_srst <= 1'b1;
            req       <= 1'b1;
          end
        end
        H_REQ: begin
          if (ack_sync) begin
            st  <= H_DROP;
            req <= 1'b0;
          end
        end
        H_DROP: begin
          if (!ack_sync) begin
            st   <= H_IDLE;
            busy <= 1'b0;
          end
        end
        default: begin
          st   <= H_IDLE;
          busy <= 1'b0;
          req  <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/srst_eng_ctl.sv
module srst_eng_ctl
  import srst_pkg::*;
#(
  parameter int HOLD = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic req_sync,
  output logic eng_srst,
  output logic ack
);
  localparam int CW = $clog2(HOLD + 1);

  eng_st_t       st;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= E_IDLE;
      eng_srst <= 1'b0;
      ack      <= 1'b0;
      cnt      <= '0;
    end else begin
      case (st)
        E_IDLE: begin
          if (req_sync) begin
            st       <= E_RST;
            eng_srst <= 1'b1;
            cnt      <= CW'(1);
          end
        end
        E_RST: begin
          if (cnt >= CW'(HOLD)) begin
            st       <= E_ACK;
            eng_srst <= 1'b0;
            ack      <= 1'b1;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        E_ACK: begin
          if (!req_sync) begin
            st  <= E_IDLE;
            ack <= 1'b0;
          end
        end
        default: begin
          st       <= E_IDLE;
          eng_srst <= 1'b0;
          ack      <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/srst_handshake.sv
module srst_handshake #(
  parameter int SYNC_STAGES = 2,
  parameter int ENG_HOLD    = 2
) (
  input  logic host_clk,
  input  logic host_rst,
  input  logic eng_clk,
  input  logic eng_rst,
  input  logic wr_en,
  input  logic wr_bit,
  output logic busy,
  output logic host_srst,
  output logic eng_srst
);
  localparam int HOLD_EFF = (ENG_HOLD < 1) ? 1 : ENG_HOLD;

  logic req_h;
  logic req_e_s;
  logic ack_e;
  logic ack_h_s;

  srst_host_ctl u_host (
    .clk       (host_clk),
    .rst       (host_rst),
    .wr_en     (wr_en),
    .wr_bit    (wr_bit),
    .ack_sync  (ack_h_s),
    .busy      (busy),
    .host_srst (host_srst),
    .req       (req_h)
  );

  srst_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk (eng_clk),
    .rst (eng_rst),
    .d   (req_h),
    .q   (req_e_s)
  );

  srst_eng_ctl #(.HOLD(HOLD_EFF)) u_eng (
    .clk      (eng_clk),
    .rst      (eng_rst),
    .req_sync (req_e_s),
    .eng_srst (eng_srst),
    .ack      (ack_e)
  );

  srst_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk (host_clk),
    .rst (host_rst),
    .d   (ack_e),
    .q   (ack_h_s)
  );
endmodule

// File: rtl/srst_handshake_chk.sv
module srst_handshake_chk (
  input logic host_clk,
  input logic host_rst,
  input logic eng_clk,
  input logic eng_rst,
  input logic wr_en,
  input logic wr_bit,
  input logic busy,
  input logic host_srst,
  input logic eng_srst,
  input logic req_h,
  input logic ack_e,
  input logic req_e_s,
  input logic ack_h_s
);
  assert_idle_after_reset_R1: assert property (@(posedge host_clk)
    host_rst |=> (!busy && !host_srst));

  assert_busy_set_R2: assert property (@(posedge host_clk) disable iff (host_rst)
    (wr_en && wr_bit && !busy) |=> busy);

  assert_host_pulse_start_R3: assert property (@(posedge host_clk) disable iff (host_rst)
    host_srst |-> $rose(busy));

  assert_host_pulse_single_R3: assert property (@(posedge host_clk) disable iff (host_rst)
    host_srst |=> !host_srst);

  assert_ignore_clear_bit_R4: assert property (@(posedge host_clk) disable iff (host_rst)
    (wr_en && !wr_bit && !busy) |=> !busy);

  assert_eng_needs_req_R5: assert property (@(posedge eng_clk) disable iff (eng_rst)
    $rose(eng_srst) |-> req_e_s);

  assert_eng_no_ack_during_R5: assert property (@(posedge eng_clk) disable iff (eng_rst)
    eng_srst |-> !ack_e);

  assert_ack_after_eng_R6: assert property (@(posedge eng_clk) disable iff (eng_rst)
    $fell(eng_srst) |-> ack_e);

  assert_busy_clear_late_R6: assert property (@(posedge host_clk) disable iff (host_rst)
    $fell(busy) |-> (!ack_h_s && !req_h));

  assert_req_inside_busy_R6: assert property (@(posedge host_clk) disable iff (host_rst)
    req_h |-> busy);
endmodule

bind srst_handshake srst_handshake_chk u_chk (
  .host_clk  (host_clk),
  .host_rst  (host_rst),
  .eng_clk   (eng_clk),
  .eng_rst   (eng_rst),
  .wr_en     (wr_en),
  .wr_bit    (wr_bit),
  .busy      (busy),
  .host_srst (host_srst),
  .eng_srst  (eng_srst),
  .req_h     (req_h),
  .ack_e     (ack_e),
  .req_e_s   (req_e_s),
  .ack_h_s   (ack_h_s)
);

// File: tb/tb_srst_handshake.sv
`timescale 1ns/1ps
module tb_srst_handshake;
  localparam int  S    = 2;
  localparam int  HOLD = 2;
  localparam real TH   = 5.0;

  logic host_clk = 1'b0;
  logic eng_clk  = 1'b0;
  logic host_rst = 1'b1;
  logic eng_rst  = 1'b1;
  logic wr_en    = 1'b0;
  logic wr_bit   = 1'b0;
  logic busy, host_srst, eng_srst;

  realtime eh = 3.5;
  int checks = 0;
  int errors = 0;
  int hcyc   = 0;

  srst_handshake #(.SYNC_STAGES(S), .ENG_HOLD(HOLD)) dut (
    .host_clk  (host_clk),
    .host_rst  (host_rst),
    .eng_clk   (eng_clk),
    .eng_rst   (eng_rst),
    .wr_en     (wr_en),
    .wr_bit    (wr_bit),
    .busy      (busy),
    .host_srst (host_srst),
    .eng_srst  (eng_srst)
  );

  initial forever #(TH / 2.0) host_clk = ~host_clk;
  initial forever #(eh) eng_clk = ~eng_clk;

  // engine-side pulse monitor
  int      pulses = 0;
  int      run    = 0;
  int      last_w = 0;
  realtime t_erise = 0.0;
  realtime t_efall = 0.0;
  always @(negedge eng_clk) begin
    if (eng_srst) begin
      if (run == 0) t_erise = $realtime;
      run = run + 1;
    end else if (run != 0) begin
      last_w  = run;
      pulses  = pulses + 1;
      t_efall = $realtime;
      run     = 0;
    end
  end

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge host_clk) begin
    hcyc = hcyc + 1;
    if (hcyc > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: act %0d exp %0d", hcyc, 150000);
      finish_run();
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: act %0d exp %0d", req, act, exp);
    end
  endtask

  task automatic apply_reset();
    @(negedge host_clk);
    host_rst = 1'b1; eng_rst = 1'b1; wr_en = 1'b0; wr_bit = 1'b0;
    repeat (4) @(posedge eng_clk);
    repeat (4) @(posedge host_clk);
    @(negedge host_clk);
    chk(!busy && !host_srst && !eng_srst, "R1 outputs in reset",
        {busy, host_srst, eng_srst}, 0);
    host_rst = 1'b0;
    @(posedge eng_clk);
    #0.1 eng_rst = 1'b0;
    @(negedge host_clk);
    chk(!busy && !host_srst && !eng_srst, "R1 outputs after release",
        {busy, host_srst, eng_srst}, 0);
  endtask

  // one full reset; optionally an extra trigger while busy
  task automatic one_reset(input bit extra);
    int      p0 = pulses;
    realtime tb_rise;
    realtime tb_fall;
    int      n  = 0;
    @(negedge host_clk);
    wr_en = 1'b1; wr_bit = 1'b1;
    @(negedge host_clk);
    tb_rise = $realtime;
    chk(busy == 1'b1, "R2 busy after write", busy, 1);
    chk(host_srst == 1'b1, "R3 host pulse with busy rise", host_srst, 1);
    wr_en = 1'b0; wr_bit = 1'b0;
    @(negedge host_clk);
    chk(host_srst == 1'b0, "R3 host pulse one cycle", host_srst, 0);
    if (extra) begin
      wr_en = 1'b1; wr_bit = 1'b1;
      @(negedge host_clk);
      wr_en = 1'b0; wr_bit = 1'b0;
    end
    while (busy && n < 2000) begin
      @(negedge host_clk);
      n = n + 1;
    end
    tb_fall = $realtime;
    chk(!busy, "R6 busy clears", busy, 0);
    repeat (3 * S + 6) @(negedge host_clk);
    chk(pulses - p0 == 1, "R4 R5 one engine pulse per reset", pulses - p0, 1);
    chk(last_w == HOLD, "R5 engine pulse width", last_w, HOLD);
    chk(t_erise > tb_rise - TH && t_erise - tb_rise <= (S + 2) * 2.0 * eh + TH,
        "R5 engine pulse start (ps)", longint'((t_erise - tb_rise) * 1000.0), 0);
    chk(tb_fall > t_efall, "R6 busy outlives engine pulse (ps)",
        longint'((tb_fall - t_efall) * 1000.0), 1);
    chk(tb_fall - t_efall <= (2 * S + 4) * TH + (S + 2) * 2.0 * eh + TH,
        "R6 busy clear latency (ps)", longint'((tb_fall - t_efall) * 1000.0),
        longint'(((2 * S + 4) * TH + (S + 2) * 2.0 * eh + TH) * 1000.0));
  endtask

  task automatic ignored(input bit en, input bit bitv, input string tag);
    int p0 = pulses;
    int hi = 0;
    @(negedge host_clk);
    wr_en = en; wr_bit = bitv;
    @(negedge host_clk);
    wr_en = 1'b0; wr_bit = 1'b0;
    for (int i = 0; i < 40; i++) begin
      if (busy || host_srst) hi = hi + 1;
      @(negedge host_clk);
    end
    chk(hi == 0, tag, hi, 0);
    chk(pulses == p0, "R4 no engine pulse", pulses - p0, 0);
  endtask

  task automatic back_to_back();
    int gaps = 0;
    int low  = 0;
    bit seen = 1'b0;
    int n    = 0;
    @(negedge host_clk);
    wr_en = 1'b1; wr_bit = 1'b1;
    while (gaps < 3 && n < 5000) begin
      @(negedge host_clk);
      n = n + 1;
      if (busy) begin
        if (seen && low != 0) begin
          chk(low == 1, "R7 busy low gap", low, 1);
          gaps = gaps + 1;
        end
        seen = 1'b1;
        low  = 0;
      end else if (seen) begin
        low = low + 1;
      end
    end
    chk(gaps == 3, "R7 gaps observed", gaps, 3);
    wr_en = 1'b0; wr_bit = 1'b0;
    n = 0;
    while (busy && n < 2000) begin
      @(negedge host_clk);
      n = n + 1;
    end
    repeat (3 * S + 6) @(negedge host_clk);
  endtask

  initial begin
    realtime halves[5] = '{3.5, 1.3, 2.0, 6.0, 11.0};
    for (int k = 0; k < 5; k++) begin
      host_rst = 1'b1; eng_rst = 1'b1;
      eh = halves[k];
      apply_reset();
      ignored(1'b1, 1'b0, "R4 write with bit clear");
      ignored(1'b0, 1'b1, "R4 bit set without strobe");
      one_reset(1'b0);
      one_reset(1'b1);
      back_to_back();
      one_reset(1'b0);
    end
    finish_run();
  end
endmodule